// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Preamble Queueing

This block is the transmit half of an asynchronous serial port. Software loads an 8- or 9-bit word into a one-entry holding register. The transmitter frames the word with a start bit and a stop bit and shifts it out least significant bit first. Each bit lasts one period of an external bit-rate enable pulse. Besides data frames, the block can send break frames (a run of low bits followed by a high stop bit) and preamble frames (a whole frame of high bits). The break length depends on the word length and on a long-break (LIN master) option. A preamble is requested by dropping the enable low and raising it again while a frame is on the line. A single break is requested by setting the break control and then clearing it. In both cases the request waits until the frame in progress has ended. Holding the break control high sends break frames back to back.

The block also merges the enabled transmitter flags with the receiver flags, which come in as inputs, into one interrupt request. It reports that request as a one-cycle pulse on each rising edge, so that an edge-triggered interrupt controller can take it. The serial output comes with a separate output-enable, and the pad cell turns this into a tristate driver.

The frame state machine has the states IDLE, START, DATA, STOP, BRK_LOW, BRK_STOP and PRE, and all of its transitions happen on a bit tick. The transitions are:
- START to DATA.
- DATA to DATA until the last data bit, then DATA to STOP.
- BRK_LOW to BRK_STOP after the last low bit.
- PRE stays in PRE until its last bit.
- IDLE, STOP, BRK_STOP and the last PRE bit share one "launch" choice that picks the next state:
  - IDLE if the enable is low.
  - Otherwise BRK_LOW if a break is held or queued.
  - Otherwise PRE if a preamble is queued.
  - Otherwise START if the holding register is full.
  - Otherwise IDLE.

Top module: `async_tx_brk`

## Requirements
- R1: After reset, txd is 1, txd_oe is 0, tx_empty is 1, tx_done is 1 and irq_pulse is 0.
- R2: txd_oe is 1 exactly while cfg_tx_en is 1. No new frame starts while cfg_tx_en is 0, and an idle line holds txd at 1.
- R3: A data frame is one start bit (0), then 8 data bits (cfg_word9=0) or 9 data bits (cfg_word9=1) least significant bit first, then one stop bit (1). Every bit lasts exactly one bit-tick period.
- R4: tx_empty falls on a write to the holding register. It rises when the held word moves into the shifter, and only then.
- R5: tx_done is 0 while a frame is being sent. It becomes 1 when a frame ends and nothing else is waiting to be sent.
- R6: A 1-to-0 change on cfg_brk queues one break frame. That frame starts right after the stop bit of the word in progress and never shortens that word.
- R7: A break frame has this many low bits, followed by one high stop bit:
  - 10 when cfg_lin_brk=0 and cfg_word9=0
  - 11 when cfg_lin_brk=0 and cfg_word9=1
  - 13 when cfg_lin_brk=1 and cfg_word9=0
  - 14 when cfg_lin_brk=1 and cfg_word9=1
- R8: While cfg_brk is held at 1, break frames repeat with exactly one high bit between consecutive low runs.
- R9: A 0-then-1 pulse on cfg_tx_en during a frame queues one preamble. The preamble is 10 or 11 high bits (following cfg_word9), sent after the current word and before any held data word. Queued items launch in this priority: break first, then preamble, then data.
- R10: The interrupt request is the OR of four terms: ie_tx_empty with tx_empty, ie_tx_done with tx_done, ie_rx with (rx_full or rx_overrun), and ie_rx_idle with rx_line_idle. With every enable at 0 there is no interrupt.
- R11: irq_pulse is high for exactly one clock cycle, one cycle after each 0-to-1 change of the combined request. It does not go high again while the request stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit-rate enable, one pulse per bit period |
| dr_wr | input | 1 | Write strobe for the holding register |
| dr_wdata | input | 9 | Word to transmit (bit 8 used only for 9-bit words) |
| cfg_word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_brk | input | 1 | Break control |
| cfg_lin_brk | input | 1 | Long break (LIN master) option |
| ie_tx_empty | input | 1 | Interrupt enable for tx_empty |
| ie_tx_done | input | 1 | Interrupt enable for tx_done |
| ie_rx | input | 1 | Interrupt enable for receiver full or overrun |
| ie_rx_idle | input | 1 | Interrupt enable for receiver idle line |
| rx_full | input | 1 | Receiver data-ready flag |
| rx_overrun | input | 1 | Receiver overrun flag |
| rx_line_idle | input | 1 | Receiver idle-line flag |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Output enable for the serial pad |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmission complete |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench measures the low run of a break for all four combinations of word length and long-break option. An off-by-one in the length counter, or a long-break offset added for the wrong word length, would show up as a wrong bit count. It queues a break and a preamble during a word of all ones. A design that launched either one too early would shorten that word, and one that left the request behind would not start the break or preamble right at the stop bit. A held data word must follow the preamble at exactly twenty bit periods from the first start bit; a wrong launch priority would send it ten bits early. The interrupt tests hold one request source high while adding a second. A level output, or an edge detector that fires again, would give more than one pulse.

// File: rtl/atx_pkg.sv
package atx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE     = 3'd0,
        TX_START    = 3'd1,
        TX_DATA     = 3'd2,
        TX_STOP     = 3'd3,
        TX_BRK_LOW  = 3'd4,
        TX_BRK_STOP = 3'd5,
        TX_PRE      = 3'd6
    } tx_state_e;

    // Index of each interrupt source in the request vector
    localparam int IRQ_TXE  = 0;
    localparam int IRQ_TXC  = 1;
    localparam int IRQ_RX   = 2;
    localparam int IRQ_IDLE = 3;
    localparam int IRQ_SRCS = 4;

endpackage

// File: rtl/atx_req_queue.sv
// Edge detectors that queue one-shot break and preamble requests.
module atx_req_queue (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic brk_ctl,
    input  logic busy,
    input  logic take_brk,
    input  logic take_pre,
    output logic brk_pend,
    output logic pre_pend
);

    logic en_q;
    logic brk_q;
    logic brk_fall;
    logic en_rise_busy;

    assign brk_fall     = brk_q & ~brk_ctl;
    assign en_rise_busy = tx_en & ~en_q & busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            brk_q    <= 1'b0;
            brk_pend <= 1'b0;
            pre_pend <= 1'b0;
        end else begin
            en_q  <= tx_en;
            brk_q <= brk_ctl;
            // a fresh request in the same cycle as a launch wins
            if (brk_fall)
                brk_pend <= 1'b1;
            else if (take_brk)
                brk_pend <= 1'b0;
            if (en_rise_busy)
                pre_pend <= 1'b1;
            else if (take_pre)
                pre_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/atx_frame_fsm.sv
// Bit-level frame sequencer: data, break and preamble frames.
module atx_frame_fsm
    import atx_pkg::*;
#(
    parameter int DATA_BITS = 9,
    parameter int LIN_EXTRA = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 tx_en,
    input  logic                 word9,
    input  logic                 lin_mode,
    input  logic                 brk_hold,
    input  logic                 brk_pend,
    input  logic                 pre_pend,
    input  logic                 buf_full,
    input  logic [DATA_BITS-1:0] buf_word,
    output logic                 take_brk,
    output logic                 take_pre,
    output logic                 take_data,
    output logic                 done_set,
    output logic                 busy,
    output logic                 txd,
    output tx_state_e            state_o
);

    localparam int CNT_W = $clog2(DATA_BITS + 2 + LIN_EXTRA);

    tx_state_e            st, st_n;
    logic [CNT_W-1:0]     cnt, cnt_n;
    logic [DATA_BITS-1:0] sh, sh_n;
    logic                 txd_q, txd_n;
    logic [CNT_W-1:0]     last_data, last_frame, last_brk;
    logic                 launch, from_frame;

    assign last_data  = word9 ? CNT_W'(DATA_BITS - 1) : CNT_W'(DATA_BITS - 2);
    assign last_frame = word9 ? CNT_W'(DATA_BITS + 1) : CNT_W'(DATA_BITS);
    assign last_brk   = last_frame + (lin_mode ? CNT_W'(LIN_EXTRA) : '0);

    // next-state and launch decision
    always_comb begin
        st_n       = st;
        cnt_n      = cnt;
        sh_n       = sh;
        txd_n      = txd_q;
        take_brk   = 1'b0;
        take_pre   = 1'b0;
        take_data  = 1'b0;
        done_set   = 1'b0;
        launch     = 1'b0;
        from_frame = 1'b0;
        if (bit_tick) begin
            unique case (st)
                TX_IDLE: begin
                    launch = 1'b1;
                end
                TX_START: begin
                    st_n  = TX_DATA;
                    cnt_n = '0;
                    txd_n = sh[0];
                    sh_n  = sh >> 1;
                end
                TX_DATA: begin
                    if (cnt == last_data) begin
                        st_n  = TX_STOP;
                        txd_n = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                        txd_n = sh[0];
                        sh_n  = sh >> 1;
                    end
                end
                TX_STOP, TX_BRK_STOP: begin
                    launch     = 1'b1;
                    from_frame = 1'b1;
                end
                TX_BRK_LOW: begin
                    if (cnt == last_brk) begin
                        st_n  = TX_BRK_STOP;
                        txd_n = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                TX_PRE: begin
                    if (cnt == last_frame) begin
                        launch     = 1'b1;
                        from_frame = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: begin
                    st_n  = TX_IDLE;
                    txd_n = 1'b1;
                end
            endcase
        end
        if (launch) begin
            cnt_n = '0;
            if (!tx_en) begin
                st_n     = TX_IDLE;
                txd_n    = 1'b1;
                done_set = from_frame;
            end else if (brk_hold || brk_pend) begin
                st_n     = TX_BRK_LOW;
                txd_n    = 1'b0;
                take_brk = 1'b1;
            end else if (pre_pend) begin
                st_n     = TX_PRE;
                txd_n    = 1'b1;
                take_pre = 1'b1;
            end else if (buf_full) begin
                st_n      = TX_START;
                txd_n     = 1'b0;
                sh_n      = buf_word;
                take_data = 1'b1;
            end else begin
                st_n     = TX_IDLE;
                txd_n    = 1'b1;
                done_set = from_frame;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            cnt   <= '0;
            sh    <= '0;
            txd_q <= 1'b1;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            sh    <= sh_n;
            txd_q <= txd_n;
        end
    end

    // outputs
    always_comb begin
        txd     = txd_q;
        busy    = (st != TX_IDLE);
        state_o = st;
    end

endmodule

// File: rtl/atx_irq_edge.sv
// Combines enabled flags and emits a one-cycle pulse on each rising edge.
module atx_irq_edge #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] enable,
    input  logic [N_SRC-1:0] flag,
    output logic             pulse
);

    logic req, req_q, pulse_q;

    assign req = |(enable & flag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            req_q   <= req;
            pulse_q <= req & ~req_q;
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/async_tx_brk.sv
module async_tx_brk
    import atx_pkg::*;
#(
    parameter int DATA_BITS = 9,
    parameter int LIN_EXTRA = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 dr_wr,
    input  logic [DATA_BITS-1:0] dr_wdata,
    input  logic                 cfg_word9,
    input  logic                 cfg_tx_en,
    input  logic                 cfg_brk,
    input  logic                 cfg_lin_brk,
    input  logic                 ie_tx_empty,
    input  logic                 ie_tx_done,
    input  logic                 ie_rx,
    input  logic                 ie_rx_idle,
    input  logic                 rx_full,
    input  logic                 rx_overrun,
    input  logic                 rx_line_idle,
    output logic                 txd,
    output logic                 txd_oe,
    output logic                 tx_empty,
    output logic                 tx_done,
    output logic                 irq_pulse
);

    logic [DATA_BITS-1:0] hold_word;
    logic                 empty_q, done_q;
    logic                 brk_pend, pre_pend, busy;
    logic                 take_brk, take_pre, take_data, done_set;
    logic                 any_take;
    tx_state_e            fsm_state;
    logic [IRQ_SRCS-1:0]  irq_en, irq_flag;

    assign any_take = take_brk | take_pre | take_data;

    // holding register and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_word <= '0;
            empty_q   <= 1'b1;
            done_q    <= 1'b1;
        end else begin
            if (dr_wr) begin
                hold_word <= dr_wdata;
                empty_q   <= 1'b0;
            end else if (take_data) begin
                empty_q   <= 1'b1;
            end
            if (any_take)
                done_q <= 1'b0;
            else if (done_set)
                done_q <= 1'b1;
        end
    end

    atx_req_queue u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (cfg_tx_en),
        .brk_ctl  (cfg_brk),
        .busy     (busy),
        .take_brk (take_brk),
        .take_pre (take_pre),
        .brk_pend (brk_pend),
        .pre_pend (pre_pend)
    );

    atx_frame_fsm #(
        .DATA_BITS (DATA_BITS),
        .LIN_EXTRA (LIN_EXTRA)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_en     (cfg_tx_en),
        .word9     (cfg_word9),
        .lin_mode  (cfg_lin_brk),
        .brk_hold  (cfg_brk),
        .brk_pend  (brk_pend),
        .pre_pend  (pre_pend),
        .buf_full  (~empty_q),
        .buf_word  (hold_word),
        .take_brk  (take_brk),
        .take_pre  (take_pre),
        .take_data (take_data),
        .done_set  (done_set),
        .busy      (busy),
        .txd       (txd),
        .state_o   (fsm_state)
    );

    assign irq_en[IRQ_TXE]    = ie_tx_empty;
    assign irq_en[IRQ_TXC]    = ie_tx_done;
    assign irq_en[IRQ_RX]     = ie_rx;
    assign irq_en[IRQ_IDLE]   = ie_rx_idle;
    assign irq_flag[IRQ_TXE]  = empty_q;
    assign irq_flag[IRQ_TXC]  = done_q;
    assign irq_flag[IRQ_RX]   = rx_full | rx_overrun;
    assign irq_flag[IRQ_IDLE] = rx_line_idle;

    atx_irq_edge #(
        .N_SRC (IRQ_SRCS)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (irq_en),
        .flag   (irq_flag),
        .pulse  (irq_pulse)
    );

    assign txd_oe   = cfg_tx_en;
    assign tx_empty = empty_q;
    assign tx_done  = done_q;

endmodule

// File: rtl/atx_checker.sv
module atx_checker
    import atx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bit_tick,
    input logic      txd,
    input logic      tx_empty,
    input logic      tx_done,
    input logic      irq_pulse,
    input tx_state_e st
);

    // R3: the line only changes on a bit tick
    a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

    // R2: an idle shifter keeps the line high
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE) |-> txd);

    // R4: the holding register empties only on a bit tick
    a_r4_empty_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(bit_tick));

    // R5: completion is flagged only with the shifter idle
    a_r5_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (st == TX_IDLE));

    // R7: the break low phase really drives the line low
    a_r7_brk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_BRK_LOW) |-> !txd);

    // R11: the interrupt pulse is one cycle wide
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

endmodule

bind async_tx_brk atx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .txd       (txd),
    .tx_empty  (tx_empty),
    .tx_done   (tx_done),
    .irq_pulse (irq_pulse),
    .st        (fsm_state)
);

// File: tb/async_tx_brk_bench.sv
`timescale 1ns/1ps
module async_tx_brk_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       dr_wr = 1'b0;
    logic [8:0] dr_wdata = '0;
    logic       cfg_word9 = 1'b0, cfg_tx_en = 1'b0, cfg_brk = 1'b0, cfg_lin_brk = 1'b0;
    logic       ie_tx_empty = 1'b0, ie_tx_done = 1'b0, ie_rx = 1'b0, ie_rx_idle = 1'b0;
    logic       rx_full = 1'b0, rx_overrun = 1'b0, rx_line_idle = 1'b0;
    logic       txd, txd_oe, tx_empty, tx_done, irq_pulse;

    int checks = 0;
    int fails  = 0;
    logic bitlog [0:4095];
    int   nbit = 0;
    int   divcnt = 0;
    logic tick_seen = 1'b0;

    always #4 clk = ~clk;

    async_tx_brk u_async_tx_brk (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
        .cfg_word9(cfg_word9), .cfg_tx_en(cfg_tx_en), .cfg_brk(cfg_brk), .cfg_lin_brk(cfg_lin_brk),
        .ie_tx_empty(ie_tx_empty), .ie_tx_done(ie_tx_done), .ie_rx(ie_rx), .ie_rx_idle(ie_rx_idle),
        .rx_full(rx_full), .rx_overrun(rx_overrun), .rx_line_idle(rx_line_idle),
        .txd(txd), .txd_oe(txd_oe), .tx_empty(tx_empty), .tx_done(tx_done), .irq_pulse(irq_pulse)
    );

    // bit tick every 4 clocks, driven away from the active edge
    always @(negedge clk) begin
        divcnt   = (divcnt + 1) % 4;
        bit_tick = (divcnt == 0);
    end
    always @(posedge clk) tick_seen <= bit_tick;
    // one log entry per bit period, sampled after the edge that moved the line
    always @(negedge clk) begin
        if (tick_seen) begin
            if (nbit < 4096) bitlog[nbit] = txd;
            nbit++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        int t = nbit + n;
        while (nbit < t) @(negedge clk);
    endtask

    function automatic int find_lvl(input int from, input logic lv);
        for (int i = from; i < nbit && i < 4096; i++)
            if (bitlog[i] === lv) return i;
        return -1;
    endfunction

    function automatic int run_len(input int from, input logic lv);
        int n = 0;
        for (int i = from; i < nbit && i < 4096; i++) begin
            if (bitlog[i] !== lv) break;
            n++;
        end
        return n;
    endfunction

    function automatic int word_at(input int s, input int nb);
        int v = 0;
        for (int i = 0; i < nb; i++)
            if (bitlog[s + 1 + i] === 1'b1) v |= (1 << i);
        return v;
    endfunction

    task automatic write_word(input logic [8:0] w);
        @(negedge clk);
        dr_wr = 1'b1; dr_wdata = w;
        @(negedge clk);
        dr_wr = 1'b0;
    endtask

    task automatic settle();
        while (!tx_done) @(negedge clk);
        wait_bits(2);
    endtask

    task automatic t_reset();
        chk("R1 txd", txd, 1);
        chk("R1 txd_oe", txd_oe, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 tx_done", tx_done, 1);
        chk("R1 irq_pulse", irq_pulse, 0);
    endtask

    task automatic t_data(input logic m, input logic [8:0] w);
        int mark, s, nb;
        nb = m ? 9 : 8;
        settle();
        cfg_word9 = m;
        mark = nbit;
        write_word(w);
        chk("R4 empty cleared by write", tx_empty, 0);
        wait_bits(3);
        chk("R4 empty after launch", tx_empty, 1);
        chk("R5 done low while busy", tx_done, 0);
        wait_bits(nb + 2);
        s = find_lvl(mark, 1'b0);
        chk("R3 data bits", word_at(s, nb), int'(w) & ((1 << nb) - 1));
        chk("R3 stop bit", bitlog[s + nb + 1], 1);
        wait_bits(2);
        chk("R5 done after frame", tx_done, 1);
    endtask

    task automatic t_break(input logic m, input logic lin, input int exp_low);
        int mark, s, nb;
        nb = m ? 9 : 8;
        settle();
        cfg_word9 = m; cfg_lin_brk = lin;
        mark = nbit;
        write_word(9'h1FF);
        wait_bits(3);
        @(negedge clk); cfg_brk = 1'b1;
        @(negedge clk); @(negedge clk); cfg_brk = 1'b0;
        wait_bits(nb + exp_low + 8);
        s = find_lvl(mark, 1'b0);
        chk("R6 word not cut", run_len(s + 1, 1'b1), nb + 1);
        chk("R7 break low bits", run_len(s + nb + 2, 1'b0), exp_low);
        chk("R7 break stop", bitlog[s + nb + 2 + exp_low], 1);
        cfg_lin_brk = 1'b0;
    endtask

    task automatic t_held_break();
        int mark, z, ones;
        settle();
        cfg_word9 = 1'b0;
        mark = nbit;
        @(negedge clk); cfg_brk = 1'b1;
        wait_bits(30);
        @(negedge clk); cfg_brk = 1'b0;
        z = find_lvl(mark, 1'b0);
        chk("R8 first low run", run_len(z, 1'b0), 10);
        ones = run_len(z + 10, 1'b0 ? 1'b0 : 1'b1);
        chk("R8 one high between", ones, 1);
        chk("R8 second low run", run_len(z + 11, 1'b0), 10);
        settle();
        chk("R8 line idle after release", txd, 1);
    endtask

    task automatic t_preamble();
        int mark, s;
        settle();
        cfg_word9 = 1'b0;
        mark = nbit;
        write_word(9'h03C);
        wait_bits(2);
        write_word(9'h081);
        @(negedge clk); cfg_tx_en = 1'b0;
        @(negedge clk);
        chk("R2 oe low with enable low", txd_oe, 0);
        @(negedge clk); cfg_tx_en = 1'b1;
        wait_bits(32);
        s = find_lvl(mark, 1'b0);
        chk("R9 first word", word_at(s, 8), 'h3C);
        chk("R9 preamble high run", run_len(s + 9, 1'b1), 11);
        chk("R9 second word start", bitlog[s + 20], 0);
        chk("R9 second word", word_at(s + 20, 8), 'h81);
    endtask

    task automatic t_disabled();
        int mark, s;
        settle();
        cfg_tx_en = 1'b0;
        mark = nbit;
        write_word(9'h055);
        wait_bits(14);
        chk("R2 oe while disabled", txd_oe, 0);
        chk("R2 word held while disabled", tx_empty, 0);
        chk("R2 line stays high", find_lvl(mark, 1'b0), -1);
        @(negedge clk); cfg_tx_en = 1'b1;
        chk("R2 oe follows enable", txd_oe, 1);
        mark = nbit;
        wait_bits(14);
        s = find_lvl(mark, 1'b0);
        chk("R2 start within two bits", (s >= mark && s <= mark + 2) ? 1 : 0, 1);
        chk("R2 word sent after enable", word_at(s, 8), 'h55);
    endtask

    task automatic count_irq(input int ncyc, output int pulses, output int wide);
        logic prev = 1'b0;
        pulses = 0; wide = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (irq_pulse && !prev) pulses++;
            if (irq_pulse && prev) wide++;
            prev = irq_pulse;
        end
    endtask

    task automatic t_irq();
        int p, w;
        settle();
        rx_full = 1'b1; rx_overrun = 1'b1; rx_line_idle = 1'b1;
        count_irq(12, p, w);
        chk("R10 no irq with enables off", p, 0);
        rx_full = 1'b0; rx_overrun = 1'b0; rx_line_idle = 1'b0;
        ie_tx_empty = 1'b1;
        count_irq(12, p, w);
        chk("R10 tx_empty source", p, 1);
        chk("R11 pulse width", w, 0);
        ie_rx = 1'b1; rx_overrun = 1'b1;
        count_irq(12, p, w);
        chk("R11 no second pulse while request high", p, 0);
        ie_tx_empty = 1'b0; rx_overrun = 1'b0; ie_rx = 1'b0;
        count_irq(4, p, w);
        ie_rx = 1'b1; rx_full = 1'b1;
        count_irq(12, p, w);
        chk("R10 rx full source", p, 1);
        ie_rx = 1'b0; rx_full = 1'b0;
        count_irq(4, p, w);
        ie_rx_idle = 1'b1; rx_line_idle = 1'b1;
        count_irq(12, p, w);
        chk("R10 idle source", p, 1);
        ie_rx_idle = 1'b0; rx_line_idle = 1'b0;
        count_irq(4, p, w);
        ie_tx_done = 1'b1;
        count_irq(12, p, w);
        chk("R10 done source", p, 1);
        ie_tx_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg_tx_en = 1'b1;
        wait_bits(2);
        t_data(1'b0, 9'h0A5);
        t_data(1'b1, 9'h15A);
        t_break(1'b0, 1'b0, 10);
        t_break(1'b1, 1'b0, 11);
        t_break(1'b0, 1'b1, 13);
        t_break(1'b1, 1'b1, 14);
        t_held_break();
        t_preamble();
        t_disabled();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule